// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block assembles one cache line from a memory bus narrower than the line. When the cache reports a miss, the block takes the miss address and issues a single burst request that begins at the bus-wide chunk holding the missed byte. The memory side then returns the line one chunk per beat in wrapped order: the requested chunk, then the chunks at the next higher indices, wrapping back to index zero.

The first beat is passed straight to the core on an early-restart output, together with the 32-bit word the core asked for, so execution can resume while the rest of the line is still arriving. Each beat is written into its own slot of a single-line buffer according to its position in the line, so the completed line comes out in address order. Once the last beat is stored, the block pulses a line-complete strobe that carries the whole line and its tag for the cache to write. With the default parameters a 32-byte line arrives over a 64-bit bus in four beats. Tag lookup and bus arbitration are outside this block.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset `miss_ready` is 1 and `req_valid`, `early_valid` and `line_valid` are 0. `miss_ready` is 1 exactly when no fill is in progress. A `miss_valid` raised while a fill is in progress is ignored: it produces no request and does not change the tag of the line being filled.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. On the next cycle `req_valid` is 1 for exactly one cycle, and `req_addr` equals the miss address with its three lowest bits cleared, which is the address of the critical chunk.
- R3: The critical chunk index is miss address bits [4:3]. The k-th beat of a fill (k = 0..3) is stored in slot (index + k) mod 4. For example, a miss at byte 0x95 fills the slots in the order 2, 3, 0, 1.
- R4: The cycle after the first beat of a fill is accepted, `early_valid` is 1 for exactly one cycle and `early_chunk` equals that beat's data.
- R5: `early_word` is `early_chunk[31:0]` when miss address bit 2 is 0, and `early_chunk[63:32]` when it is 1.
- R6: The cycle after the fourth beat is accepted, `line_valid` is 1 for exactly one cycle. In that cycle slot i of the line appears on `line_data[64*i+63:64*i]`, and `line_tag` equals miss address bits [31:5].
- R7: `line_valid` stays 0 until all four beats of the fill have been accepted. Cycles in which `beat_valid` is 0 only delay the fill and are not counted as beats.
- R8: A `beat_valid` seen while no fill is in progress is ignored. It raises neither `early_valid` nor `line_valid`, and it does not count toward the next fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Byte address of the missed access |
| miss_ready | output | 1 | High when idle and able to accept a miss |
| req_valid | output | 1 | One-cycle burst request to memory |
| req_addr | output | 32 | Chunk-aligned start address of the wrapped burst |
| beat_valid | input | 1 | Memory beat present |
| beat_data | input | 64 | Memory beat data |
| early_valid | output | 1 | One-cycle pulse: critical chunk available |
| early_chunk | output | 64 | Critical chunk data |
| early_word | output | 32 | Requested 32-bit word within the critical chunk |
| line_valid | output | 1 | One-cycle pulse: whole line assembled |
| line_data | output | 256 | Assembled line, slot 0 in the low bits |
| line_tag | output | 27 | Line address (miss address bits [31:5]) |

## Verification
The hardest behaviour to reach from the ports is the mapping from arrival order to slot under a critical index that is not zero, combined with stray or early inputs. Stray beats sent before a fill would show up as a wrong slot mapping, and a second miss raised partway through a fill would show up as a second request or a changed tag. The stimulus covers every critical index, both word halves, and idle gaps between beats. It injects beats while the block is idle just before a fill and raises a second miss between beats of a fill in progress. It then checks the early outputs, every slot of the completed line and the tag against a model that places beat k at slot (index + k) mod 4.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/cwf_slot_calc.sv
// Maps the beat ordinal of a wrapped burst to its slot in the line.
module cwf_slot_calc #(
    parameter int CHUNKS = 4,
    localparam int IDX_W = $clog2(CHUNKS)
) (
    input  logic [IDX_W-1:0] crit_idx,
    input  logic [IDX_W-1:0] beat_ord,
    output logic [IDX_W-1:0] slot_idx,
    output logic             last_beat
);
    // CHUNKS is a power of two, so the wrap is the natural overflow.
    always_comb begin
        slot_idx  = crit_idx + beat_ord;
        last_beat = (beat_ord == IDX_W'(CHUNKS - 1));
    end
endmodule

// File: rtl/cwf_line_store.sv
// Single-line buffer, one register per chunk slot.
module cwf_line_store #(
    parameter int CHUNK_W = 64,
    parameter int CHUNKS  = 4,
    localparam int IDX_W  = $clog2(CHUNKS),
    localparam int LINE_W = CHUNK_W * CHUNKS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_slot,
    input  logic [CHUNK_W-1:0] wr_data,
    output logic [LINE_W-1:0]  line_out
);
    for (genvar gi = 0; gi < CHUNKS; gi++) begin : g_slot
        logic [CHUNK_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_slot == IDX_W'(gi))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign line_out[gi*CHUNK_W +: CHUNK_W] = slot_q;
    end
endmodule

// File: rtl/cwf_word_pick.sv
// Selects one core word out of a bus chunk.
module cwf_word_pick #(
    parameter int CHUNK_W = 64,
    parameter int WORD_W  = 32,
    localparam int WORDS  = CHUNK_W / WORD_W,
    localparam int SEL_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [CHUNK_W-1:0] chunk,
    input  logic [SEL_W-1:0]   sel,
    output logic [WORD_W-1:0]  word
);
    logic [WORD_W-1:0] lanes [WORDS];

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_lane
        assign lanes[gw] = chunk[gw*WORD_W +: WORD_W];
    end

    always_comb begin
        word = lanes[0];
        for (int i = 0; i < WORDS; i++) begin
            if (sel == SEL_W'(i)) begin
                word = lanes[i];
            end
        end
    end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BUS_W      = 64,
    parameter int LINE_BYTES = 32,
    parameter int WORD_W     = 32,
    localparam int CHUNKS    = (LINE_BYTES * 8) / BUS_W,
    localparam int IDX_W     = $clog2(CHUNKS),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int CHUNK_OFF = $clog2(BUS_W / 8),
    localparam int WORD_OFF  = $clog2(WORD_W / 8),
    localparam int WSEL_W    = (BUS_W / WORD_W > 1) ? $clog2(BUS_W / WORD_W) : 1,
    localparam int TAG_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              miss_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              beat_valid,
    input  logic [BUS_W-1:0]  beat_data,
    output logic              early_valid,
    output logic [BUS_W-1:0]  early_chunk,
    output logic [WORD_W-1:0] early_word,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_data,
    output logic [TAG_W-1:0]  line_tag
);
    typedef struct packed {
        fill_state_e        state;
        logic [IDX_W-1:0]   crit;
        logic [IDX_W-1:0]   ord;
        logic [WSEL_W-1:0]  wsel;
        logic [TAG_W-1:0]   tag;
        logic [ADDR_W-1:0]  req_addr;
        logic               req_v;
        logic               early_v;
        logic [BUS_W-1:0]   early_chunk;
        logic               line_v;
    } fill_st_t;

    fill_st_t st_d, st_q;

    logic             take_beat;
    logic [IDX_W-1:0] wr_slot;
    logic             last_beat;

    assign take_beat = (st_q.state == FS_FILL) && beat_valid;

    cwf_slot_calc #(.CHUNKS(CHUNKS)) u_slot (
        .crit_idx (st_q.crit),
        .beat_ord (st_q.ord),
        .slot_idx (wr_slot),
        .last_beat(last_beat)
    );

    cwf_line_store #(.CHUNK_W(BUS_W), .CHUNKS(CHUNKS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_beat),
        .wr_slot (wr_slot),
        .wr_data (beat_data),
        .line_out(line_data)
    );

    cwf_word_pick #(.CHUNK_W(BUS_W), .WORD_W(WORD_W)) u_pick (
        .chunk(st_q.early_chunk),
        .sel  (st_q.wsel),
        .word (early_word)
    );

    always_comb begin
        st_d         = st_q;
        st_d.req_v   = 1'b0;
        st_d.early_v = 1'b0;
        st_d.line_v  = 1'b0;
        case (st_q.state)
            FS_IDLE: begin
                if (miss_valid) begin
                    st_d.state    = FS_FILL;
                    st_d.crit     = miss_addr[CHUNK_OFF +: IDX_W];
                    st_d.ord      = '0;
                    st_d.wsel     = miss_addr[WORD_OFF +: WSEL_W];
                    st_d.tag      = miss_addr[ADDR_W-1:OFF_W];
                    st_d.req_addr = {miss_addr[ADDR_W-1:CHUNK_OFF], CHUNK_OFF'(0)};
                    st_d.req_v    = 1'b1;
                end
            end
            FS_FILL: begin
                if (beat_valid) begin
                    st_d.ord = st_q.ord + 1'b1;
                    if (st_q.ord == '0) begin
                        st_d.early_v     = 1'b1;
                        st_d.early_chunk = beat_data;
                    end
                    if (last_beat) begin
                        st_d.line_v = 1'b1;
                        st_d.state  = FS_IDLE;
                    end
                end
            end
            default: st_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miss_ready  = (st_q.state == FS_IDLE);
    assign req_valid   = st_q.req_v;
    assign req_addr    = st_q.req_addr;
    assign early_valid = st_q.early_v;
    assign early_chunk = st_q.early_chunk;
    assign line_valid  = st_q.line_v;
    assign line_tag    = st_q.tag;
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
    parameter int CHUNKS = 4,
    localparam int CNT_W = $clog2(CHUNKS) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic miss_valid,
    input logic miss_ready,
    input logic req_valid,
    input logic beat_valid,
    input logic early_valid,
    input logic line_valid
);
    logic [CNT_W-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (miss_valid && miss_ready) begin
            beats_q <= '0;
        end else if (beat_valid && !miss_ready) begin
            beats_q <= beats_q + 1'b1;
        end
    end

    // R2
    req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> req_valid);

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R1
    busy_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !miss_ready);

    // R4
    early_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |=> !early_valid);

    // R4
    early_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        early_valid |-> (beats_q == CNT_W'(1)));

    // R6
    line_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> !line_valid);

    // R7
    line_all_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (beats_q == CNT_W'(CHUNKS)));

    // R1
    idle_at_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> miss_ready);
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.CHUNKS(CHUNKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .miss_ready (miss_ready),
    .req_valid  (req_valid),
    .beat_valid (beat_valid),
    .early_valid(early_valid),
    .line_valid (line_valid)
);

// File: tb/sim_cwf_line_fill.sv
module sim_cwf_line_fill;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         miss_valid = 1'b0;
    logic [31:0]  miss_addr = '0;
    logic         miss_ready;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic         beat_valid = 1'b0;
    logic [63:0]  beat_data = '0;
    logic         early_valid;
    logic [63:0]  early_chunk;
    logic [31:0]  early_word;
    logic         line_valid;
    logic [255:0] line_data;
    logic [26:0]  line_tag;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cwf_line_fill u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .req_valid(req_valid), .req_addr(req_addr),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .early_valid(early_valid), .early_chunk(early_chunk), .early_word(early_word),
        .line_valid(line_valid), .line_data(line_data), .line_tag(line_tag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(miss_ready == 1'b1, "R1 ready after reset", 64'(miss_ready), 64'd1);
        chk(req_valid == 1'b0 && early_valid == 1'b0 && line_valid == 1'b0,
            "R1 pulses low after reset",
            64'({req_valid, early_valid, line_valid}), 64'd0);
    endtask

    // One wrapped fill; gap inserts idle cycles between beats, poke raises a
    // second miss in the middle of the fill.
    task automatic t_fill(input logic [31:0] addr, input logic [31:0] seed,
                          input bit gap, input bit poke);
        logic [63:0]  d [4];
        logic [255:0] exp_line;
        int crit;
        crit = int'(addr[4:3]);
        for (int k = 0; k < 4; k++) begin
            d[k] = {seed, 32'(k) ^ 32'h5A5A_0000};
            exp_line[((crit + k) % 4)*64 +: 64] = d[k];
        end
        chk(miss_ready == 1'b1, "R1 ready before miss", 64'(miss_ready), 64'd1);
        miss_valid = 1'b1;
        miss_addr  = addr;
        @(negedge clk);
        miss_valid = 1'b0;
        // R2: request the cycle after acceptance
        chk(req_valid == 1'b1, "R2 req pulse", 64'(req_valid), 64'd1);
        chk(req_addr == {addr[31:3], 3'b000}, "R2 req addr", 64'(req_addr),
            64'({addr[31:3], 3'b000}));
        chk(miss_ready == 1'b0, "R1 busy during fill", 64'(miss_ready), 64'd0);
        for (int k = 0; k < 4; k++) begin
            if (gap && k > 0) begin
                @(negedge clk);
                // R7: idle cycle is not a beat
                chk(line_valid == 1'b0, "R7 no line in gap", 64'(line_valid), 64'd0);
            end
            beat_valid = 1'b1;
            beat_data  = d[k];
            if (poke && k == 1) begin
                miss_valid = 1'b1;
                miss_addr  = addr ^ 32'h0001_0000;
            end
            @(negedge clk);
            beat_valid = 1'b0;
            if (poke && k == 1) begin
                miss_valid = 1'b0;
                miss_addr  = addr;
                // R1: miss while busy is ignored
                chk(req_valid == 1'b0, "R1 busy miss ignored", 64'(req_valid), 64'd0);
            end
            if (k == 0) begin
                // R4 / R5
                chk(early_valid == 1'b1, "R4 early pulse", 64'(early_valid), 64'd1);
                chk(early_chunk == d[0], "R4 early chunk", early_chunk, d[0]);
                chk(early_word == (addr[2] ? d[0][63:32] : d[0][31:0]),
                    "R5 early word", 64'(early_word),
                    64'(addr[2] ? d[0][63:32] : d[0][31:0]));
            end else begin
                chk(early_valid == 1'b0, "R4 early single", 64'(early_valid), 64'd0);
            end
            if (k < 3) begin
                chk(line_valid == 1'b0, "R7 no early line", 64'(line_valid), 64'd0);
            end
        end
        // R6 / R3
        chk(line_valid == 1'b1, "R6 line pulse", 64'(line_valid), 64'd1);
        for (int s = 0; s < 4; s++) begin
            chk(line_data[s*64 +: 64] == exp_line[s*64 +: 64], "R3 slot placement",
                line_data[s*64 +: 64], exp_line[s*64 +: 64]);
        end
        chk(line_tag == addr[31:5], "R6 line tag", 64'(line_tag), 64'(addr[31:5]));
        @(negedge clk);
        chk(line_valid == 1'b0, "R6 line single", 64'(line_valid), 64'd0);
        chk(miss_ready == 1'b1, "R1 ready after fill", 64'(miss_ready), 64'd1);
    endtask

    task automatic t_idle_beats();
        for (int i = 0; i < 2; i++) begin
            beat_valid = 1'b1;
            beat_data  = 64'hDEAD_BEEF_0000_0000 | 64'(i);
            @(negedge clk);
            beat_valid = 1'b0;
            // R8: stray beat has no effect
            chk(early_valid == 1'b0 && line_valid == 1'b0, "R8 idle beat ignored",
                64'({early_valid, line_valid}), 64'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill(32'h0000_0095, 32'h1111_0001, 1'b0, 1'b0);
        t_fill(32'h0000_1240, 32'h2222_0002, 1'b0, 1'b0);
        t_fill(32'hFFFF_FFFC, 32'h3333_0003, 1'b1, 1'b0);
        t_fill(32'h0000_0008, 32'h4444_0004, 1'b0, 1'b1);
        t_idle_beats();
        t_fill(32'hABCD_0113, 32'h5555_0005, 1'b1, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule